// File: doc/BRIEF.md
# 16-bit Command Word Serial Slave

This block is a four-wire serial slave in SPI mode 0 that takes fixed 16-bit command words from a host. The top four bits of a word are a command code. The low twelve bits are its parameter. A code of zero means a status read. Any other code selects one of a set of parameter registers and writes the twelve parameter bits into it. The block sends a 16-bit status word back on SDO during every transfer, so reading status and writing a register share the same bit periods.

The chip-select, serial clock and data inputs are oversampled by a system clock that runs at least four times faster than the serial clock. Each of these inputs passes through a two-stage synchronizer. The interface goes back to its idle state whenever chip-select is high. A register is only written when chip-select rises after exactly sixteen serial-clock rising edges. A power-on reset loads every parameter register with a computed default value.

Top module: `cmd_spi_slave`

## Requirements
- R1: After reset, parameter register k (numbered from 1) holds the low 12 bits of k*0x111, `wr_stb` is 0 and `sdo` is 0.
- R2: SDI is sampled on rising SCK edges while `cs_n` is low, with the most significant bit first. Bits 15..12 of the assembled word form the code and bits 11..0 form the parameter.
- R3: A code in the range 1..NREG writes the 12-bit parameter into register number `code`. A code above NREG changes no register and raises no strobe.
- R4: Code 0 is a status read. It changes no register and raises no strobe.
- R5: `sdo` is 0 whenever `cs_n` is high.
- R6: `status_in` is captured when `cs_n` falls. Its bit 15 is on `sdo` before the first rising SCK edge, and each later bit appears after a falling SCK edge, most significant bit first. Changes to `status_in` during the transfer do not alter the bits shifted out.
- R7: A write happens only when `cs_n` rises after exactly 16 rising SCK edges. A transfer of 15 or 17 edges is dropped.
- R8: Each accepted write raises `wr_stb` for exactly one system-clock cycle, with `wr_addr` equal to the code. Register contents change only in that cycle.
- R9: Raising `cs_n` clears the bit count, so a complete transfer that follows an aborted one is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from the host |
| status_in | input | 16 | Status word to send to the host |
| sdo | output | 1 | Serial data to the host |
| wr_stb | output | 1 | One-cycle pulse when a register is written |
| wr_addr | output | 4 | Code of the last written register |
| ctrl_regs | output | NREG*12 | All parameter registers, register k at bits [k*12-1:(k-1)*12] |

## Verification
Within one transfer the block shifts the status word out and shifts the command word in, so the outgoing status and the incoming register write always overlap. The bench provokes this by sending write words while a distinctive status pattern is loaded, and it changes `status_in` halfway through the word. Each such transfer is judged twice. The sixteen SDO bits must equal the status value present at the falling edge of chip-select. The addressed register, and no other, must take the new parameter with exactly one strobe cycle.

// File: rtl/cmd_spi_slave.sv
module cmd_spi_slave #(
  parameter int NREG = 15,
  parameter int PW = 12,
  parameter logic [11:0] DEF_STEP = 12'h111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic [15:0]       status_in,
  output logic              sdo,
  output logic              wr_stb,
  output logic [3:0]        wr_addr,
  output logic [NREG*PW-1:0] ctrl_regs
);
  localparam int WW = PW + 4;
  localparam int CW = 5;

  logic [2:0] sck_sy, cs_sy;
  logic [1:0] sdi_sy;
  logic [CW-1:0] bit_cnt;
  logic [WW-1:0] rx_sh, tx_sh;
  logic sdo_r;
  logic [PW-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sy <= '0;
      cs_sy  <= '1;
      sdi_sy <= '0;
    end else begin
      sck_sy <= {sck_sy[1:0], sck};
      cs_sy  <= {cs_sy[1:0], cs_n};
      sdi_sy <= {sdi_sy[0], sdi};
    end

  wire sck_rise = sck_sy[1] & ~sck_sy[2];
  wire sck_fall = ~sck_sy[1] & sck_sy[2];
  wire cs_q     = cs_sy[1];
  wire cs_fall  = ~cs_sy[1] & cs_sy[2];
  wire cs_rise  = cs_sy[1] & ~cs_sy[2];
  wire [3:0] cmd = rx_sh[WW-1 -: 4];
  wire commit = cs_rise && bit_cnt == CW'(WW) && cmd != 4'd0 && int'(cmd) <= NREG;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      sdo_r   <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (cs_q) begin
        bit_cnt <= '0;
        sdo_r   <= 1'b0;
        if (commit) begin
          wr_stb  <= 1'b1;
          wr_addr <= cmd;
        end
      end else if (cs_fall) begin
        bit_cnt <= '0;
        tx_sh   <= status_in;
        sdo_r   <= status_in[WW-1];
      end else begin
        if (sck_rise) begin
          rx_sh <= {rx_sh[WW-2:0], sdi_sy[1]};
          if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
        end
        if (sck_fall) begin
          tx_sh <= {tx_sh[WW-2:0], 1'b0};
          sdo_r <= tx_sh[WW-2];
        end
      end
    end

  for (genvar k = 1; k <= NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        regs[k-1] <= PW'(k * int'(DEF_STEP));
      else if (commit && cmd == 4'(k))
        regs[k-1] <= rx_sh[PW-1:0];
    assign ctrl_regs[k*PW-1 -: PW] = regs[k-1];
  end

  assign sdo = sdo_r & ~cs_n;
endmodule

module cmd_spi_slave_chk #(
  parameter int NREG = 15,
  parameter int PW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [3:0]        wr_addr,
  input logic [NREG*PW-1:0] ctrl_regs,
  input logic              cs_q,
  input logic [4:0]        bit_cnt,
  input logic              sdo_r
);
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb); // R8
  AST_REG_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n) !$stable(ctrl_regs) |-> wr_stb); // R8
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> (wr_addr != 4'd0 && int'(wr_addr) <= NREG)); // R3
  AST_STB_AFTER_16: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> $past(bit_cnt) == 5'd16); // R7
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cs_q |=> bit_cnt == 5'd0); // R9
  AST_SDO_DESEL: assert property (@(posedge clk) disable iff (!rst_n) cs_q |=> !sdo_r); // R5
endmodule

bind cmd_spi_slave cmd_spi_slave_chk #(.NREG(NREG), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .ctrl_regs(ctrl_regs), .cs_q(cs_q), .bit_cnt(bit_cnt), .sdo_r(sdo_r)
);

// File: tb/tb_cmd_spi_slave.sv
module tb_cmd_spi_slave;
  localparam int NREG = 12;
  localparam int PW = 12;
  localparam int HALF = 40;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, sdi = 0;
  logic [15:0] status_in = '0;
  logic sdo, wr_stb;
  logic [3:0] wr_addr;
  logic [NREG*PW-1:0] ctrl_regs;

  int tests = 0, fails = 0, stb_cycles = 0;
  logic [3:0] last_addr = '0;
  logic [PW-1:0] model [1:NREG];

  cmd_spi_slave #(.NREG(NREG), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .status_in(status_in), .sdo(sdo), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .ctrl_regs(ctrl_regs)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (wr_stb) begin
    stb_cycles++;
    last_addr = wr_addr;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int k = 1; k <= NREG; k++)
      check(tag, 32'(ctrl_regs[k*PW-1 -: PW]), 32'(model[k]));
  endtask

  task automatic xfer(input logic [15:0] word, input int nbits, input logic [15:0] mid_stat,
                      output logic [15:0] got);
    got = '0;
    cs_n = 0;
    #60;
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? word[15-i] : 1'b0;
      if (i == 8) status_in = mid_stat;
      #HALF;
      if (i < 16) got[15-i] = sdo;
      sck = 1;
      #HALF;
      sck = 0;
    end
    #HALF;
    cs_n = 1;
    #120;
  endtask

  task automatic t_reset;
    for (int k = 1; k <= NREG; k++) model[k] = PW'(k * 'h111);
    check("R1 sdo", 32'(sdo), 0);
    check("R1 wr_stb", 32'(wr_stb), 0);
    check_regs("R1 defaults");
  endtask

  task automatic t_write(input logic [15:0] w, input logic [15:0] st);
    logic [15:0] got;
    int s0 = stb_cycles;
    status_in = st;
    xfer(w, 16, st ^ 16'hFFFF, got);
    model[w[15:12]] = w[11:0];
    check("R2 R3 write", 32'(ctrl_regs[w[15:12]*PW-1 -: PW]), 32'(w[11:0]));
    check_regs("R3 others unchanged");
    check("R8 one strobe cycle", 32'(stb_cycles - s0), 1);
    check("R8 wr_addr", 32'(last_addr), 32'(w[15:12]));
    check("R6 status during write", 32'(got), 32'(st));
    check("R5 sdo low after", 32'(sdo), 0);
  endtask

  task automatic t_nowrite(input string tag, input logic [15:0] w, input int nbits, input logic [15:0] st);
    logic [15:0] got;
    int s0 = stb_cycles;
    status_in = st;
    xfer(w, nbits, 16'h0000, got);
    check_regs(tag);
    check({tag, " strobe"}, 32'(stb_cycles - s0), 0);
    if (nbits >= 16) check("R6 status shifted", 32'(got), 32'(st));
  endtask

  task automatic t_desel;
    status_in = 16'hFFFF;
    for (int i = 0; i < 4; i++) begin
      #37;
      check("R5 sdo desel", 32'(sdo), 0);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #30;
    t_reset;
    rst_n = 1;
    #50;
    t_desel;
    t_write(16'h3ABC, 16'hA55A);
    t_write(16'hC5A5, 16'h8001);
    t_write(16'h1800, 16'h1234);
    t_write(16'h7001, 16'hFFFF);
    t_nowrite("R4 status read", 16'h0123, 16, 16'hC3E1);
    t_nowrite("R3 code above range", 16'hD111, 16, 16'h0F0F);
    t_nowrite("R3 code 15", 16'hF000, 16, 16'h7FFE);
    t_nowrite("R7 fifteen bits", 16'h2FFF, 15, 16'h0000);
    t_nowrite("R7 seventeen bits", 16'h2FFF, 17, 16'h0000);
    t_write(16'h2777, 16'h5AA5);
    check("R9 recovery", 32'(ctrl_regs[2*PW-1 -: PW]), 32'h777);
    t_desel;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule